// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits in the read path of a flash device. It drives the read data while an internally timed byte program or full-array erase is running. A one-cycle start request launches the operation. A program request also captures the target address and data byte. A counter then holds the block busy for a fixed number of clock cycles, set by a parameter for each operation kind.

While busy, the block replaces two bits of the array data with status. The top bit is a polling flag: on a program it is the inverted top bit of the byte being written, and on an erase it is zero. The bit below it flips once for every new read access. A read access begins when the chip-enable and output-enable strobes (both active low) are first low together. A host can use either flag, or both, to find the end of the operation.

When the counter expires, the block raises a one-cycle done pulse and returns to passing array data through unchanged. The busy flag and the done pulse are outputs, so that a bench can match status reads against the operation's progress.

Top module: `flash_status_reporter`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `rd_data` equals `array_data`.
- R2: A program request accepted at a clock edge keeps `busy` high for exactly PROG_CYCLES cycles. `done` is high for the single cycle after the last busy cycle, and it is never high while `busy` is high.
- R3: An accepted erase request keeps `busy` high for exactly ERASE_CYCLES cycles and ends with the same one-cycle `done` pulse.
- R4: During a program, a read at the captured address returns, on bit DATA_W-1, the inverse of bit DATA_W-1 of the captured byte. A read at any other address passes that bit from `array_data`.
- R5: During an erase, bit DATA_W-1 of `rd_data` is 0 at every address.
- R6: Each operation clears the toggle state. The k-th read access inside the operation (k = 1, 2, ...) returns k mod 2 on bit DATA_W-2.
- R7: Either strobe can complete an access. A falling `ce_n` while `oe_n` is already low counts as an access, and so does a falling `oe_n` while `ce_n` is already low.
- R8: An access held over several cycles counts once, and bit DATA_W-2 stays constant for its whole length.
- R9: Once `busy` is low, all bits of `rd_data` equal `array_data`, and bit DATA_W-2 no longer changes between accesses.
- R10: Start requests that arrive while busy are ignored. They do not change the operation kind, the captured byte or the remaining length.
- R11: During any operation, bits DATA_W-3 down to 0 of `rd_data` pass from `array_data`.
- R12: If program and erase requests arrive in the same cycle, the erase is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_prog | input | 1 | One-cycle byte program request |
| start_erase | input | 1 | One-cycle full erase request |
| prog_addr | input | ADDR_W | Address of the byte being programmed |
| prog_data | input | DATA_W | Byte being programmed |
| ce_n | input | 1 | Chip-enable read strobe, active low |
| oe_n | input | 1 | Output-enable read strobe, active low |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Stored data at `rd_addr` |
| rd_data | output | DATA_W | Read data with status substitution |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The bench runs a sweep of program bytes with both top-bit values and changes the strobe that completes each access. It runs an odd or even number of reads per operation, so a toggle state that is not cleared between operations, or that is sampled one cycle late, shows as a first read returning 0. Each access is held for several cycles, which exposes a design that counts clocks rather than accesses. Busy lengths are counted to the cycle, which catches an off-by-one in the counter load. Starts injected while busy and simultaneous requests expose a design that restarts or picks the wrong kind: the captured top bit is chosen so that every wrong outcome reads differently.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  // Erase takes precedence when both requests coincide.
  function automatic op_kind_e pick_kind(input logic erase_req);
    return erase_req ? OP_ERASE : OP_PROG;
  endfunction

  function automatic int unsigned op_length(input op_kind_e kind,
                                            input int unsigned prog_len,
                                            input int unsigned erase_len);
    return (kind == OP_ERASE) ? erase_len : prog_len;
  endfunction

  // Polling flag: erased cells read as ones, so the flag shows zero.
  function automatic logic poll_flag(input op_kind_e kind, input logic loaded_msb);
    return (kind == OP_ERASE) ? 1'b0 : ~loaded_msb;
  endfunction

  // Value shown on the toggle bit: the new state is visible from the first
  // cycle of an access, before the register has advanced.
  function automatic logic toggle_shown(input logic state, input logic new_access);
    return state ^ new_access;
  endfunction

endpackage

// File: rtl/fsr_op_timer.sv
module fsr_op_timer
  import fsr_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output op_kind_e          kind,
  output logic [ADDR_W-1:0] loaded_addr,
  output logic [DATA_W-1:0] loaded_data
);

  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic [CNT_W-1:0] remain_q;
  op_kind_e         next_kind;
  logic             last_tick;

  assign accept    = (start_prog | start_erase) & ~busy;
  assign next_kind = pick_kind(start_erase);
  assign last_tick = busy && (remain_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      kind        <= OP_PROG;
      remain_q    <= '0;
      loaded_addr <= '0;
      loaded_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        kind     <= next_kind;
        remain_q <= CNT_W'(op_length(next_kind, PROG_CYCLES, ERASE_CYCLES) - 1);
        if (next_kind == OP_PROG) begin
          loaded_addr <= prog_addr;
          loaded_data <= prog_data;
        end
      end else if (last_tick) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  // R2: the end pulse only follows a busy cycle and never overlaps one
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10: nothing captured changes while an operation continues
  assert_kind_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(kind) && $stable(loaded_data) && $stable(loaded_addr)));

endmodule

// File: rtl/fsr_access_detect.sv
module fsr_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic new_access
);

  logic access_now;
  logic access_q;

  assign access_now = ~ce_n & ~oe_n;
  assign new_access = access_now & ~access_q;

  always_ff @(posedge clk) begin
    if (!rst_n) access_q <= 1'b0;
    else        access_q <= access_now;
  end

  // R8: an access held low produces one event, not one per cycle
  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    new_access |=> !new_access);

endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle
  import fsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy,
  input  logic new_access,
  output logic shown
);

  logic state_q;
  logic advance;

  assign advance = busy & new_access;
  assign shown   = toggle_shown(state_q, advance);

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= 1'b0;
    else if (clear)   state_q <= 1'b0;
    else if (advance) state_q <= ~state_q;
  end

  // R6: each access during an operation flips the state
  assert_toggle_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && new_access && !clear) |=> (state_q != $past(state_q)));

  // R8: without a new access the state holds
  assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!new_access && !clear) |=> $stable(state_q));

endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
  import fsr_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              accept;
  op_kind_e          kind;
  logic [ADDR_W-1:0] loaded_addr;
  logic [DATA_W-1:0] loaded_data;
  logic              new_access;
  logic              tog_shown;
  logic              addr_hit;

  fsr_op_timer #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .accept     (accept),
    .busy       (busy),
    .done       (done),
    .kind       (kind),
    .loaded_addr(loaded_addr),
    .loaded_data(loaded_data)
  );

  fsr_access_detect u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .new_access(new_access)
  );

  fsr_toggle u_toggle (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .busy      (busy),
    .new_access(new_access),
    .shown     (tog_shown)
  );

  assign addr_hit = (rd_addr == loaded_addr);

  always_comb begin
    rd_data = array_data;
    if (busy) begin
      rd_data[TOG_BIT] = tog_shown;
      if (kind == OP_ERASE || addr_hit) begin
        rd_data[POLL_BIT] = poll_flag(kind, loaded_data[POLL_BIT]);
      end
    end
  end

  // R9: idle reads are plain array data
  assert_pass_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == array_data));

  // R5: erase status reads zero on the polling bit
  assert_erase_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == OP_ERASE) |-> (rd_data[POLL_BIT] == 1'b0));

endmodule

// File: tb/flash_status_reporter_bench.sv
module flash_status_reporter_bench;

  localparam int PC = 24;
  localparam int EC = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_prog = 1'b0;
  logic        start_erase = 1'b0;
  logic [15:0] prog_addr = '0;
  logic [7:0]  prog_data = '0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [15:0] rd_addr = '0;
  logic [7:0]  array_data;
  logic [7:0]  rd_data;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] arr(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] pattern(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h7F;
      2: return 8'h80;
      3: return 8'hFF;
      4: return 8'h3C;
      default: return 8'hC3;
    endcase
  endfunction

  assign array_data = arr(rd_addr);

  flash_status_reporter #(
    .ADDR_W(16), .DATA_W(8), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
  ) u_flash_status_reporter (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .prog_addr(prog_addr), .prog_data(prog_data), .ce_n(ce_n), .oe_n(oe_n),
    .rd_addr(rd_addr), .array_data(array_data), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0: both strobes fall together; 1: ce_n completes; 2: oe_n completes
  task automatic rd(input int mode, input logic [15:0] a,
                    output logic [7:0] d1, output logic [7:0] d2);
    @(negedge clk);
    rd_addr = a;
    if (mode == 1) oe_n = 1'b0;
    if (mode == 2) ce_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    #2 d1 = rd_data;
    @(negedge clk);
    @(negedge clk);
    #2 d2 = rd_data;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic launch(input logic er, input logic pr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_addr = a; prog_data = d; start_prog = pr; start_erase = er;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_done(input string tag);
    while (busy) @(negedge clk);
    chk({tag, " done pulse"}, 32'(done), 32'd1);
    @(negedge clk);
    chk({tag, " done single"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d1, d2, e;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(0, 16'h1234, d1, d2);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 data", 32'(d1), 32'(arr(16'h1234)));

    // R2 / R3: busy lengths
    launch(1'b0, 1'b1, 16'h0010, 8'h55);
    measure(n);
    chk("R2 program length", 32'(n), 32'(PC));
    chk("R2 done pulse", 32'(done), 32'd1);
    @(negedge clk);
    chk("R2 done single", 32'(done), 32'd0);
    launch(1'b1, 1'b0, 16'h0000, 8'h00);
    measure(n);
    chk("R3 erase length", 32'(n), 32'(EC));
    chk("R3 done pulse", 32'(done), 32'd1);

    // Program sweep: R4, R6, R7, R8, R11, R9
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a;
      logic [15:0] ra;
      int nr;
      int mode;
      a  = 16'h0100 * 16'(i) + 16'h0033;
      nr = 3 + (i % 2);
      launch(1'b0, 1'b1, a, pattern(i));
      for (int k = 1; k <= nr; k++) begin
        mode = (k + i) % 3;
        ra   = (k == 2) ? (a ^ 16'h0005) : a;
        rd(mode, ra, d1, d2);
        chk(mode == 0 ? "R6 toggle value" : "R7 strobe access toggle", 32'(d1[6]), 32'(k % 2));
        chk("R8 held access stable", 32'(d2[6]), 32'(d1[6]));
        e = (ra == a) ? {~pattern(i)[7], 7'd0} : {arr(ra)[7], 7'd0};
        chk("R4 polling bit", 32'(d1[7]), 32'(e[7]));
        chk("R11 low bits", 32'(d1[5:0]), 32'(arr(ra)[5:0]));
      end
      wait_done("R2 sweep");
      rd(0, a, d1, d2);
      chk("R9 true data", 32'(d1), 32'(arr(a)));
      rd(0, a, d1, d2);
      chk("R9 toggle stopped", 32'(d1), 32'(arr(a)));
    end

    // Erase sweep: R5, R6, R11
    for (int i = 0; i < 2; i++) begin
      logic [15:0] ra;
      launch(1'b1, 1'b0, 16'h0000, 8'h00);
      for (int k = 1; k <= 4; k++) begin
        ra = 16'h0F00 * 16'(k) + 16'(i * 7);
        rd(k % 3, ra, d1, d2);
        chk("R5 erase polling bit", 32'(d1[7]), 32'd0);
        chk("R6 erase toggle", 32'(d1[6]), 32'(k % 2));
        chk("R11 erase low bits", 32'(d1[5:0]), 32'(arr(ra)[5:0]));
      end
      wait_done("R3 sweep");
    end

    // R10: starts while busy are ignored
    launch(1'b0, 1'b1, 16'h0040, 8'h00);
    @(negedge clk);
    start_prog = 1'b1; prog_data = 8'h80;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b1;
    @(negedge clk);
    start_erase = 1'b0;
    rd(0, 16'h0040, d1, d2);
    chk("R10 captured byte kept", 32'(d1[7]), 32'd1);
    chk("R10 toggle not cleared", 32'(d1[6]), 32'd1);
    wait_done("R10");

    // R12: simultaneous requests choose erase
    launch(1'b1, 1'b1, 16'h0040, 8'h00);
    rd(0, 16'h0040, d1, d2);
    chk("R12 erase chosen", 32'(d1[7]), 32'd0);
    wait_done("R12");
    launch(1'b1, 1'b1, 16'h0040, 8'h00);
    measure(n);
    chk("R12 erase length", 32'(n), 32'(EC));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule